// File: doc/BRIEF.md
# SD Host Command Issue Unit

This unit is the command path of an SD/MMC host controller, as software sees it through its register window. Software first loads a 32-bit argument and then writes a command word. If the command word is enabled, the unit copies the index, the flags and the argument into a working copy. It then offers that copy to the serial command-line engine through a valid/ready handshake.

After the engine has taken the command, the unit either finishes at once or waits for a response report. That report carries the response bits, the responding index, an application flag, a CRC-valid flag and a timeout flag. The unit latches the response words and updates the status flags. The same command word also carries a soft reset that clears itself, and software polls it until it reads back zero.

Serialisation on the card's CMD wire happens outside this unit. The response report interface stands in for it.

Top module: `sdc_cmd_issue`

## Requirements
- R1: Offset 0 is the command word: index in bits 5:0, response-expected in bit 6, long response in bit 7, application command in bit 8, enable in bit 9 and soft reset in bit 10. A write with bit 9 set and bit 10 clear, made while idle and out of reset, raises tx_valid on the next cycle. tx_index, tx_need_rsp, tx_long and tx_app then carry those fields, and tx_arg carries the value of the argument register at offset 4 as it stood at the write.
- R2: A command word written with bit 9 clear issues nothing. tx_valid and busy stay low.
- R3: A command write made while busy is ignored. The offered fields stay stable until tx_ready is seen, and the command that is finally reported is the original one.
- R4: For a command with bit 6 clear, the cycle after the handshake sets status bit 6 (command sent) and drops busy.
- R5: A response report with rsp_crc_ok high and rsp_timeout low sets status bit 4. For a short response, offset 8 takes rsp_data[31:0] and offsets 12, 16 and 20 keep their contents. Offset 24 reads the responding index in bits 5:0 and the application flag in bit 6.
- R6: For a long response, offset 8 takes bits 31:0, offset 12 takes bits 63:32, offset 16 takes bits 95:64 and offset 20 takes bits 127:96.
- R7: A report with rsp_timeout high sets status bit 2, whatever rsp_crc_ok says. The response registers and offset 24 keep their previous contents.
- R8: A report with both flags low sets status bit 0, and the response registers keep their previous contents.
- R9: At most one of status bits 6, 4, 2 and 0 is set at any time. Accepting a new command clears all four. Status reads at offset 28.
- R10: Writing bit 10 of the command word makes bit 10 read back as 1 for RST_CYCLES cycles, after which it reads 0. The write aborts any command in flight and clears the status, the response registers, offset 24, the argument and the stored command. All register writes are ignored while bit 10 reads 1.
- R11: After rst, every register reads zero and tx_valid and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset for reads and writes |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| tx_valid | output | 1 | Command offered to the line engine |
| tx_ready | input | 1 | Line engine takes the command |
| tx_index | output | 6 | Command index |
| tx_need_rsp | output | 1 | Response expected |
| tx_long | output | 1 | 136-bit response expected |
| tx_app | output | 1 | Application command |
| tx_arg | output | DATA_W | Command argument |
| rsp_valid | input | 1 | Response report strobe |
| rsp_timeout | input | 1 | No response arrived |
| rsp_crc_ok | input | 1 | Response CRC matched |
| rsp_index | input | 6 | Index of the responding command |
| rsp_app | input | 1 | Application flag of the response |
| rsp_data | input | RSP_WORDS*DATA_W | Response bits, least significant word first |
| status_o | output | 7 | Status flags as read at offset 28 |
| busy | output | 1 | A command is in flight |

## Verification
The bench builds the unit with DATA_W=32, RSP_WORDS=4 and ADDR_W=5, so the full 128-bit long response and every register offset can be reached. It sets RST_CYCLES to 3, which keeps the self-clearing reset short. The bench can then watch the bit rise and fall, and can show that writes made inside that window are dropped. It holds the handshake and the response reports for varying delays, so overlapping command writes land both in the offer phase and in the wait-for-response phase.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int OFS_CMD    = 0;
    localparam int OFS_ARG    = 4;
    localparam int OFS_RSP0   = 8;
    localparam int OFS_RSPCMD = 24;
    localparam int OFS_STAT   = 28;

    localparam int STAT_W       = 7;
    localparam int ST_CRC_BAD   = 0;
    localparam int ST_TMO       = 2;
    localparam int ST_CRC_OK    = 4;
    localparam int ST_SENT      = 6;
    localparam int IDX_W        = 6;
    localparam int RSPCMD_W     = IDX_W + 1;

    // bit order follows the command word layout, MSB first
    typedef struct packed {
        logic             srst;
        logic             en;
        logic             app;
        logic             lng;
        logic             need;
        logic [IDX_W-1:0] idx;
    } cmd_word_t;

    localparam int CMD_W = $bits(cmd_word_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } cmd_state_e;

    typedef struct packed {
        logic sent;
        logic crc_ok;
        logic tmo;
        logic crc_bad;
    } outcome_t;

    function automatic logic [STAT_W-1:0] pack_status(outcome_t o);
        logic [STAT_W-1:0] s;
        s = '0;
        s[ST_SENT]    = o.sent;
        s[ST_CRC_OK]  = o.crc_ok;
        s[ST_TMO]     = o.tmo;
        s[ST_CRC_BAD] = o.crc_bad;
        return s;
    endfunction

endpackage

// File: rtl/sdc_srst_timer.sv
module sdc_srst_timer #(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= LOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);
endmodule

// File: rtl/sdc_cmd_fsm.sv
module sdc_cmd_fsm
    import sdc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              issue,
    input  cmd_word_t         cmd_in,
    input  logic [DATA_W-1:0] arg_in,
    input  logic              tx_ready,
    input  logic              rsp_valid,
    input  logic              rsp_timeout,
    input  logic              rsp_crc_ok,
    output cmd_word_t         cur_cmd,
    output logic [DATA_W-1:0] cur_arg,
    output logic              tx_valid,
    output logic              busy,
    output logic              waiting,
    output logic              store,
    output outcome_t          outcome
);
    cmd_state_e state;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state   <= ST_IDLE;
            cur_cmd <= '0;
            cur_arg <= '0;
            outcome <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (issue) begin
                    cur_cmd <= cmd_in;
                    cur_arg <= arg_in;
                    outcome <= '0;
                    state   <= ST_SEND;
                end
                ST_SEND: if (tx_ready) begin
                    if (cur_cmd.need) begin
                        state <= ST_WAIT;
                    end else begin
                        state        <= ST_IDLE;
                        outcome.sent <= 1'b1;
                    end
                end
                ST_WAIT: if (rsp_valid) begin
                    state <= ST_IDLE;
                    if (rsp_timeout)
                        outcome.tmo <= 1'b1;
                    else if (rsp_crc_ok)
                        outcome.crc_ok <= 1'b1;
                    else
                        outcome.crc_bad <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tx_valid = (state == ST_SEND);
    assign waiting  = (state == ST_WAIT);
    assign busy     = (state != ST_IDLE);
    assign store    = waiting && rsp_valid && !rsp_timeout && rsp_crc_ok;
endmodule

// File: rtl/sdc_rsp_store.sv
module sdc_rsp_store
    import sdc_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int RSP_WORDS = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  logic                          store,
    input  logic                          lng,
    input  logic [RSP_WORDS*DATA_W-1:0]   data,
    input  logic [IDX_W-1:0]              idx,
    input  logic                          app,
    output logic [RSP_WORDS*DATA_W-1:0]   words,
    output logic [RSPCMD_W-1:0]           rspcmd
);
    for (genvar i = 0; i < RSP_WORDS; i++) begin : g_word
        // word 0 takes every good response, the upper words only long ones
        logic take;
        assign take = store && ((i == 0) || lng);
        always_ff @(posedge clk) begin
            if (rst || clr)
                words[i*DATA_W +: DATA_W] <= '0;
            else if (take)
                words[i*DATA_W +: DATA_W] <= data[i*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            rspcmd <= '0;
        else if (store)
            rspcmd <= {app, idx};
    end
endmodule

// File: rtl/sdc_cmd_issue.sv
module sdc_cmd_issue
    import sdc_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int RSP_WORDS  = 4,
    parameter int ADDR_W     = 5,
    parameter int RST_CYCLES = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_we,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    output logic                        tx_valid,
    input  logic                        tx_ready,
    output logic [IDX_W-1:0]            tx_index,
    output logic                        tx_need_rsp,
    output logic                        tx_long,
    output logic                        tx_app,
    output logic [DATA_W-1:0]           tx_arg,
    input  logic                        rsp_valid,
    input  logic                        rsp_timeout,
    input  logic                        rsp_crc_ok,
    input  logic [IDX_W-1:0]            rsp_index,
    input  logic                        rsp_app,
    input  logic [RSP_WORDS*DATA_W-1:0] rsp_data,
    output logic [STAT_W-1:0]           status_o,
    output logic                        busy
);
    localparam int WORD_BYTES = DATA_W / 8;

    cmd_word_t         wr_cmd;
    cmd_word_t         cur_cmd;
    logic [DATA_W-1:0] arg_q;
    logic [DATA_W-1:0] cur_arg;
    logic              srst_active;
    logic              srst_start;
    logic              clr;
    logic              cmd_wr;
    logic              arg_wr;
    logic              issue;
    logic              waiting;
    logic              store;
    outcome_t          outcome;
    logic [RSP_WORDS*DATA_W-1:0] rsp_words;
    logic [RSPCMD_W-1:0]         rspcmd;

    assign wr_cmd     = cmd_word_t'(reg_wdata[CMD_W-1:0]);
    assign cmd_wr     = reg_we && (int'(reg_addr) == OFS_CMD) && !srst_active;
    assign arg_wr     = reg_we && (int'(reg_addr) == OFS_ARG) && !srst_active;
    assign srst_start = cmd_wr && wr_cmd.srst;
    assign issue      = cmd_wr && !wr_cmd.srst && wr_cmd.en && !busy;
    assign clr        = srst_start || srst_active;

    always_ff @(posedge clk) begin
        if (rst || clr)
            arg_q <= '0;
        else if (arg_wr)
            arg_q <= reg_wdata;
    end

    sdc_srst_timer #(.RST_CYCLES(RST_CYCLES)) u_srst (
        .clk    (clk),
        .rst    (rst),
        .start  (srst_start),
        .active (srst_active)
    );

    sdc_cmd_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .clr         (clr),
        .issue       (issue),
        .cmd_in      (wr_cmd),
        .arg_in      (arg_q),
        .tx_ready    (tx_ready),
        .rsp_valid   (rsp_valid),
        .rsp_timeout (rsp_timeout),
        .rsp_crc_ok  (rsp_crc_ok),
        .cur_cmd     (cur_cmd),
        .cur_arg     (cur_arg),
        .tx_valid    (tx_valid),
        .busy        (busy),
        .waiting     (waiting),
        .store       (store),
        .outcome     (outcome)
    );

    sdc_rsp_store #(.DATA_W(DATA_W), .RSP_WORDS(RSP_WORDS)) u_store (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .store  (store),
        .lng    (cur_cmd.lng),
        .data   (rsp_data),
        .idx    (rsp_index),
        .app    (rsp_app),
        .words  (rsp_words),
        .rspcmd (rspcmd)
    );

    assign tx_index    = cur_cmd.idx;
    assign tx_need_rsp = cur_cmd.need;
    assign tx_long     = cur_cmd.lng;
    assign tx_app      = cur_cmd.app;
    assign tx_arg      = cur_arg;
    assign status_o    = pack_status(outcome);

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) == OFS_CMD) begin
            reg_rdata[CMD_W-1:0] = {srst_active, cur_cmd[CMD_W-2:0]};
        end else if (int'(reg_addr) == OFS_ARG) begin
            reg_rdata = arg_q;
        end else if (int'(reg_addr) == OFS_RSPCMD) begin
            reg_rdata[RSPCMD_W-1:0] = rspcmd;
        end else if (int'(reg_addr) == OFS_STAT) begin
            reg_rdata[STAT_W-1:0] = status_o;
        end else begin
            for (int i = 0; i < RSP_WORDS; i++)
                if (int'(reg_addr) == OFS_RSP0 + i * WORD_BYTES)
                    reg_rdata = rsp_words[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/sdc_cmd_chk.sv
module sdc_cmd_chk
    import sdc_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int RSP_WORDS = 4,
    parameter int ADDR_W    = 5
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        reg_we,
    input logic [ADDR_W-1:0]           reg_addr,
    input logic [DATA_W-1:0]           reg_wdata,
    input logic                        tx_valid,
    input logic                        tx_ready,
    input logic [IDX_W-1:0]            tx_index,
    input logic                        tx_need_rsp,
    input logic [DATA_W-1:0]           tx_arg,
    input logic                        rsp_valid,
    input logic                        rsp_timeout,
    input logic                        rsp_crc_ok,
    input logic [STAT_W-1:0]           status_o,
    input logic                        busy,
    input logic                        waiting,
    input logic                        srst_active,
    input logic [RSP_WORDS*DATA_W-1:0] rsp_words
);
    logic srst_wr;
    assign srst_wr = reg_we && (int'(reg_addr) == OFS_CMD) && reg_wdata[CMD_W-1];

    p_no_enable_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !srst_active && reg_we && int'(reg_addr) == OFS_CMD && !reg_wdata[CMD_W-2])
        |=> !tx_valid);

    p_offer_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !srst_wr)
        |=> (tx_valid && $stable(tx_index) && $stable(tx_arg)));

    p_sent_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && !tx_need_rsp && !srst_wr)
        |=> (status_o[ST_SENT] && !busy));

    p_keep_on_timeout_r7: assert property (@(posedge clk) disable iff (rst)
        (waiting && rsp_valid && rsp_timeout && !srst_wr)
        |=> ($stable(rsp_words) && status_o[ST_TMO]));

    p_keep_on_crc_bad_r8: assert property (@(posedge clk) disable iff (rst)
        (waiting && rsp_valid && !rsp_timeout && !rsp_crc_ok && !srst_wr)
        |=> ($stable(rsp_words) && status_o[ST_CRC_BAD]));

    p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
        $countones({status_o[ST_SENT], status_o[ST_CRC_OK],
                    status_o[ST_TMO], status_o[ST_CRC_BAD]}) <= 1);

    p_reset_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        srst_active |-> (!tx_valid && !busy && status_o == '0));
endmodule

bind sdc_cmd_issue sdc_cmd_chk #(
    .DATA_W(DATA_W), .RSP_WORDS(RSP_WORDS), .ADDR_W(ADDR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_index    (tx_index),
    .tx_need_rsp (tx_need_rsp),
    .tx_arg      (tx_arg),
    .rsp_valid   (rsp_valid),
    .rsp_timeout (rsp_timeout),
    .rsp_crc_ok  (rsp_crc_ok),
    .status_o    (status_o),
    .busy        (busy),
    .waiting     (waiting),
    .srst_active (srst_active),
    .rsp_words   (rsp_words)
);

// File: tb/sim_sdc_cmd_issue.sv
module sim_sdc_cmd_issue;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 32;
    localparam int NW  = 4;
    localparam int AW  = 5;
    localparam int RSTC = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          tx_valid;
    logic          tx_ready = 1'b0;
    logic [5:0]    tx_index;
    logic          tx_need_rsp, tx_long, tx_app;
    logic [DW-1:0] tx_arg;
    logic          rsp_valid = 1'b0, rsp_timeout = 1'b0, rsp_crc_ok = 1'b0;
    logic [5:0]    rsp_index = '0;
    logic          rsp_app = 1'b0;
    logic [NW*DW-1:0] rsp_data = '0;
    logic [6:0]    status_o;
    logic          busy;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdc_cmd_issue #(.DATA_W(DW), .RSP_WORDS(NW), .ADDR_W(AW), .RST_CYCLES(RSTC)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_index(tx_index), .tx_need_rsp(tx_need_rsp),
        .tx_long(tx_long), .tx_app(tx_app), .tx_arg(tx_arg),
        .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .rsp_crc_ok(rsp_crc_ok),
        .rsp_index(rsp_index), .rsp_app(rsp_app), .rsp_data(rsp_data),
        .status_o(status_o), .busy(busy)
    );

    // ---------------- behavioural reference model ----------------
    int          m_state;      // 0 idle, 1 offering, 2 awaiting response
    int          m_cnt;
    int          m_prev;
    logic [9:0]  m_cmd;
    logic [31:0] m_arg, m_txarg;
    logic [6:0]  m_status;
    logic [31:0] m_rsp [4];
    logic [6:0]  m_rspcmd;

    task automatic m_clear();
        m_state = 0; m_cmd = '0; m_arg = '0; m_txarg = '0;
        m_status = '0; m_rspcmd = '0;
        for (int i = 0; i < 4; i++) m_rsp[i] = '0;
    endtask

    function automatic logic [31:0] m_read(int a);
        if (a == 0)  return {21'b0, (m_cnt > 0), m_cmd};
        if (a == 4)  return m_arg;
        if (a == 8)  return m_rsp[0];
        if (a == 12) return m_rsp[1];
        if (a == 16) return m_rsp[2];
        if (a == 20) return m_rsp[3];
        if (a == 24) return {25'b0, m_rspcmd};
        if (a == 28) return {25'b0, m_status};
        return '0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_clear();
            m_cnt = 0;
        end else if (m_cnt > 0) begin
            m_cnt = m_cnt - 1;
        end else begin
            m_prev = m_state;
            if (m_prev == 1 && tx_ready) begin
                if (m_cmd[6]) m_state = 2;
                else begin m_state = 0; m_status = 7'h40; end
            end
            if (m_prev == 2 && rsp_valid) begin
                m_state = 0;
                if (rsp_timeout) m_status = 7'h04;
                else if (rsp_crc_ok) begin
                    m_status = 7'h10;
                    m_rsp[0] = rsp_data[31:0];
                    if (m_cmd[7])
                        for (int i = 1; i < 4; i++) m_rsp[i] = rsp_data[i*32 +: 32];
                    m_rspcmd = {rsp_app, rsp_index};
                end else m_status = 7'h01;
            end
            if (reg_we && int'(reg_addr) == 0) begin
                if (reg_wdata[10]) begin
                    m_clear();
                    m_cnt = RSTC;
                end else if (reg_wdata[9] && m_prev == 0) begin
                    m_cmd = reg_wdata[9:0];
                    m_txarg = m_arg;
                    m_state = 1;
                    m_status = '0;
                end
            end else if (reg_we && int'(reg_addr) == 4) begin
                m_arg = reg_wdata;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1 tx_valid", tx_valid, m_state == 1);
            chk("R4 busy", busy, m_state != 0);
            chk("R9 status", status_o, m_status);
            chk("R5 read data", reg_rdata, m_read(int'(reg_addr)));
            if (m_state == 1) begin
                chk("R3 tx fields", {tx_app, tx_long, tx_need_rsp, tx_index},
                    {m_cmd[8], m_cmd[7], m_cmd[6], m_cmd[5:0]});
                chk("R3 tx_arg", tx_arg, m_txarg);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(int a, logic [31:0] d);
        reg_addr = AW'(a); reg_wdata = d; reg_we = 1'b1;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(string tag, int a, logic [31:0] exp);
        reg_addr = AW'(a);
        #2;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic accept(int delay);
        repeat (delay) tick();
        tx_ready = 1'b1; tick(); tx_ready = 1'b0;
    endtask

    task automatic respond(int delay, logic tmo, logic ok, logic [5:0] idx,
                           logic app, logic [127:0] d);
        repeat (delay) tick();
        rsp_valid = 1'b1; rsp_timeout = tmo; rsp_crc_ok = ok;
        rsp_index = idx; rsp_app = app; rsp_data = d;
        tick();
        rsp_valid = 1'b0; rsp_timeout = 1'b0; rsp_crc_ok = 1'b0;
    endtask

    localparam logic [127:0] LDATA = 128'h44440004_33330003_22220002_11110001;

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R11 reset state
        for (int a = 0; a < 32; a += 4) rd("R11 reset read", a, 32'h0);
        chk("R11 tx_valid idle", tx_valid, 1'b0);

        // R1 / R4: no-response command
        wr(4, 32'hA5A5_0001);
        wr(0, 32'h0000_0200);
        chk("R1 offer raised", tx_valid, 1'b1);
        chk("R1 arg offered", tx_arg, 32'hA5A5_0001);
        accept(2);
        rd("R4 command sent", 28, 32'h40);
        chk("R4 not busy", busy, 1'b0);

        // R2: enable clear
        wr(0, 32'h0000_0041);
        tick();
        chk("R2 nothing offered", tx_valid, 1'b0);
        chk("R2 not busy", busy, 1'b0);

        // R5: short response with app flag
        wr(4, 32'h1234_5678);
        wr(0, 32'h0000_0351);   // en, app, need, index 0x11
        chk("R1 fields", {tx_app, tx_long, tx_need_rsp, tx_index}, {1'b1, 1'b0, 1'b1, 6'h11});
        accept(1);
        respond(3, 1'b0, 1'b1, 6'h11, 1'b1, LDATA);
        rd("R5 crc ok flag", 28, 32'h10);
        rd("R5 word0", 8, 32'h1111_0001);
        rd("R5 word1 untouched", 12, 32'h0);
        rd("R5 rspcmd", 24, 32'h51);

        // R6: long response
        wr(0, 32'h0000_02C2);
        accept(0);
        respond(1, 1'b0, 1'b1, 6'h3F, 1'b0, ~LDATA);
        rd("R6 word0", 8,  ~32'h1111_0001);
        rd("R6 word1", 12, ~32'h2222_0002);
        rd("R6 word2", 16, ~32'h3333_0003);
        rd("R6 word3", 20, ~32'h4444_0004);

        // R7: timeout wins over crc flag
        wr(0, 32'h0000_02C9);
        accept(1);
        respond(2, 1'b1, 1'b1, 6'h09, 1'b1, LDATA);
        rd("R7 timeout flag", 28, 32'h04);
        rd("R7 word3 kept", 20, ~32'h4444_0004);
        rd("R7 rspcmd kept", 24, 32'h3F);

        // R8: crc failure
        wr(0, 32'h0000_0247);
        accept(0);
        respond(0, 1'b0, 1'b0, 6'h07, 1'b0, LDATA);
        rd("R8 crc bad flag", 28, 32'h01);
        rd("R8 word0 kept", 8, ~32'h1111_0001);

        // R3: writes while busy ignored, in both phases
        wr(4, 32'hCAFE_0000);
        wr(0, 32'h0000_0245);
        rd("R9 flags cleared on issue", 28, 32'h0);
        wr(4, 32'hDEAD_BEEF);
        wr(0, 32'h0000_0233);
        chk("R3 index kept", tx_index, 6'h05);
        chk("R3 arg kept", tx_arg, 32'hCAFE_0000);
        accept(1);
        wr(0, 32'h0000_0200);
        chk("R3 no new offer while waiting", tx_valid, 1'b0);
        respond(1, 1'b0, 1'b1, 6'h05, 1'b0, LDATA);
        rd("R3 original command reported", 24, 32'h05);
        rd("R3 command readback", 0, 32'h245);

        // R10: soft reset while waiting for a response
        wr(0, 32'h0000_02C8);
        accept(0);
        wr(0, 32'h0000_0400);
        rd("R10 reset bit set", 0, 32'h400);
        wr(4, 32'h0BAD_0BAD);
        rd("R10 write ignored during reset", 4, 32'h0);
        repeat (RSTC) tick();
        rd("R10 reset bit cleared", 0, 32'h0);
        rd("R10 response cleared", 8, 32'h0);
        rd("R10 status cleared", 28, 32'h0);
        chk("R10 nothing in flight", busy, 1'b0);

        // after reset, commands work again
        wr(0, 32'h0000_0201);
        accept(0);
        rd("R4 sent after reset", 28, 32'h40);

        repeat (2) tick();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule